// File: doc/BRIEF.md
# PLL Configuration Register Bank

This block is the software-visible settings store for a clock-synthesis PLL. A small synchronous register port lets a processor program a feedback multiply value, a reference divide value, a PLL enable, a base-clock select and an interrupt enable. The bank drives those settings straight to the PLL and clock-switch logic. Settings that would disturb a running loop are protected: the multiply and divide registers ignore writes while the PLL is enabled, and the VCO clock cannot be chosen as base clock while the multiply register holds zero.

The PLL's lock indication enters through a two-flop synchronizer. With the automatic-mode bit set, every change of the synchronized lock state, rising or falling, sets an interrupt flag. The flag is readable in the control register and is cleared by reading that register. The interrupt request output is the flag gated by the enable.

Register map (2-bit address): 0 = control, 1 = mode/status, 2 = multiply, 3 = reference divider. Read data is registered and appears one cycle after the read strobe.

Top module: `pllcfg_bank`

## Requirements
- R1: After reset the multiply register is 0x40, the divider register is 1, and PLL enable, clock select, interrupt enable, automatic mode and interrupt flag are all 0.
- R2: A write to the multiply register (address 2) is ignored while the PLL enable bit is 1.
- R3: Writing 0x00 to the multiply register while the PLL is off leaves the PLL off and clears the clock-select bit.
- R4: A control write (address 0) sets clock select (bit 4) only if the multiply register is nonzero; the enable takes bit 5 and the interrupt enable bit 6; bit 7 (flag) is not writable.
- R5: The divider register (address 3) holds bits 3..0, reads bits 7..4 as 0, and ignores writes while the PLL enable bit is 1.
- R6: The divide output equals the divider register, except that a stored 0 gives 1.
- R7: With automatic mode set (address 1 bit 0), each change of the lock input in either direction sets the flag; the flag is visible 3 clock edges after the input changes, and the lock status (address 1 bit 1) reports the synchronized lock value.
- R8: The flag is set regardless of the interrupt enable; the interrupt request is 1 only when flag and enable are both 1.
- R9: A control-register read while the flag is 1 clears the flag, unless a lock change that sets it lands in the same cycle, in which case the flag stays 1.
- R10: With automatic mode clear, lock changes do not set the flag.
- R11: A read strobe returns the addressed register on the read data output one cycle later; control reads as {flag, enable-irq, pll-on, clock-select, 0000}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 2 | Register address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| lock_i | input | 1 | Asynchronous lock indication from the PLL |
| mult_o | output | 8 | Multiply value |
| div_o | output | 4 | Effective reference divide value |
| pll_on_o | output | 1 | PLL enable |
| clk_sel_o | output | 1 | Base clock select (1 = VCO) |
| irq_o | output | 1 | Interrupt request |

## Verification
Register writes change the setting outputs and the interrupt request on the first clock edge after the strobe, and a read returns its value on that same edge, so the bench drives on the falling edge and checks at the next falling edge. A lock change needs two synchronizer edges before it shows in the status bit and a third before the flag sets, so the bench checks that the request is still low after two edges and high after three. The same-cycle clear test issues the control read exactly in the cycle where the third edge sets the flag.

// File: rtl/pllcfg_pkg.sv
package pllcfg_pkg;

    localparam int REG_W       = 8;
    localparam int DIV_W       = 4;
    localparam int ADDR_W      = 2;
    localparam int SYNC_STAGES = 2;

    localparam logic [REG_W-1:0] MULT_RST = 8'h40;
    localparam logic [DIV_W-1:0] DIV_RST  = 4'd1;

    // control register bit positions
    localparam int CB_FLAG = 7;
    localparam int CB_IE   = 6;
    localparam int CB_ON   = 5;
    localparam int CB_SEL  = 4;
    // mode register bit positions
    localparam int MB_AUTO = 0;
    localparam int MB_LOCK = 1;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL = 2'd0,
        RA_MODE = 2'd1,
        RA_MULT = 2'd2,
        RA_RDIV = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic on;
        logic sel;
        logic ie;
        logic autom;
    } pll_ctl_t;

    function automatic logic [DIV_W-1:0] eff_div(input logic [DIV_W-1:0] r);
        return (r == '0) ? DIV_W'(1) : r;
    endfunction

    function automatic logic [REG_W-1:0] pack_ctrl(input logic flag, input pll_ctl_t c);
        logic [REG_W-1:0] v;
        v = '0;
        v[CB_FLAG] = flag;
        v[CB_IE]   = c.ie;
        v[CB_ON]   = c.on;
        v[CB_SEL]  = c.sel;
        return v;
    endfunction

    function automatic logic [REG_W-1:0] pack_mode(input logic lock_sts, input pll_ctl_t c);
        logic [REG_W-1:0] v;
        v = '0;
        v[MB_AUTO] = c.autom;
        v[MB_LOCK] = lock_sts;
        return v;
    endfunction

endpackage

// File: rtl/pllcfg_settings.sv
module pllcfg_settings
    import pllcfg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_i,
    input  reg_addr_e            addr_i,
    input  logic [REG_W-1:0]     wdata_i,
    output logic [REG_W-1:0]     mult_o,
    output logic [DIV_W-1:0]     rdiv_o,
    output pll_ctl_t             ctl_o
);

    logic [REG_W-1:0] mult_q;
    logic [DIV_W-1:0] rdiv_q;
    pll_ctl_t         ctl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mult_q <= MULT_RST;
            rdiv_q <= DIV_RST;
            ctl_q  <= '0;
        end else if (wr_i) begin
            case (addr_i)
                RA_CTRL: begin
                    ctl_q.on  <= wdata_i[CB_ON];
                    ctl_q.ie  <= wdata_i[CB_IE];
                    ctl_q.sel <= wdata_i[CB_SEL] && (mult_q != '0);
                end
                RA_MODE: ctl_q.autom <= wdata_i[MB_AUTO];
                RA_MULT: begin
                    if (!ctl_q.on) begin
                        mult_q <= wdata_i;
                        if (wdata_i == '0) begin
                            ctl_q.on  <= 1'b0;
                            ctl_q.sel <= 1'b0;
                        end
                    end
                end
                RA_RDIV: begin
                    if (!ctl_q.on) rdiv_q <= wdata_i[DIV_W-1:0];
                end
                default: ;
            endcase
        end
    end

    assign mult_o = mult_q;
    assign rdiv_o = rdiv_q;
    assign ctl_o  = ctl_q;

    assert_mult_locked_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_i && addr_i == RA_MULT && ctl_q.on) |=> $stable(mult_q));

    assert_zero_mult_off_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_i && addr_i == RA_MULT && wdata_i == '0 && !ctl_q.on) |=> (!ctl_q.sel && !ctl_q.on));

    assert_no_vco_sel_R4: assert property (@(posedge clk) disable iff (rst)
        (mult_q == '0) |-> !ctl_q.sel);

    assert_rdiv_locked_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_i && addr_i == RA_RDIV && ctl_q.on) |=> $stable(rdiv_q));

endmodule

// File: rtl/pllcfg_lock_mon.sv
module pllcfg_lock_mon #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic lock_i,
    output logic lock_sts_o,
    output logic lock_chg_o
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) sync_q[0] <= 1'b0;
        else     sync_q[0] <= lock_i;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_sync
        always_ff @(posedge clk) begin
            if (rst) sync_q[g] <= 1'b0;
            else     sync_q[g] <= sync_q[g-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sync_q[STAGES-1];
    end

    assign lock_sts_o = sync_q[STAGES-1];
    assign lock_chg_o = sync_q[STAGES-1] ^ prev_q;

    // R7: a reported change is followed by a settled status for one cycle at least
    assert_chg_settles_R7: assert property (@(posedge clk) disable iff (rst)
        lock_chg_o |=> (prev_q == $past(lock_sts_o)));

endmodule

// File: rtl/pllcfg_irq_flag.sv
module pllcfg_irq_flag (
    input  logic clk,
    input  logic rst,
    input  logic auto_i,
    input  logic chg_i,
    input  logic clr_i,
    output logic flag_o
);

    logic flag_q;
    logic set_w;

    assign set_w = auto_i && chg_i;

    always_ff @(posedge clk) begin
        if (rst)        flag_q <= 1'b0;
        else if (set_w) flag_q <= 1'b1;
        else if (clr_i) flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

    assert_set_on_change_R7: assert property (@(posedge clk) disable iff (rst)
        (auto_i && chg_i) |=> flag_q);

    assert_clear_on_read_R9: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !(auto_i && chg_i)) |=> !flag_q);

    assert_no_set_manual_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(auto_i));

endmodule

// File: rtl/pllcfg_bank.sv
module pllcfg_bank
    import pllcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [REG_W-1:0]  wdata_i,
    output logic [REG_W-1:0]  rdata_o,
    input  logic              lock_i,
    output logic [REG_W-1:0]  mult_o,
    output logic [DIV_W-1:0]  div_o,
    output logic              pll_on_o,
    output logic              clk_sel_o,
    output logic              irq_o
);

    reg_addr_e         addr_w;
    logic [REG_W-1:0]  mult_w;
    logic [DIV_W-1:0]  rdiv_w;
    pll_ctl_t          ctl_w;
    logic              lock_sts_w;
    logic              lock_chg_w;
    logic              flag_w;
    logic              clr_w;
    logic [REG_W-1:0]  rd_mux_w;
    logic [REG_W-1:0]  rdata_q;

    assign addr_w = reg_addr_e'(addr_i);

    pllcfg_settings u_settings (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (wr_i),
        .addr_i  (addr_w),
        .wdata_i (wdata_i),
        .mult_o  (mult_w),
        .rdiv_o  (rdiv_w),
        .ctl_o   (ctl_w)
    );

    pllcfg_lock_mon #(.STAGES(SYNC_STAGES)) u_lock (
        .clk        (clk),
        .rst        (rst),
        .lock_i     (lock_i),
        .lock_sts_o (lock_sts_w),
        .lock_chg_o (lock_chg_w)
    );

    assign clr_w = rd_i && (addr_w == RA_CTRL) && flag_w;

    pllcfg_irq_flag u_flag (
        .clk    (clk),
        .rst    (rst),
        .auto_i (ctl_w.autom),
        .chg_i  (lock_chg_w),
        .clr_i  (clr_w),
        .flag_o (flag_w)
    );

    always_comb begin
        case (addr_w)
            RA_CTRL: rd_mux_w = pack_ctrl(flag_w, ctl_w);
            RA_MODE: rd_mux_w = pack_mode(lock_sts_w, ctl_w);
            RA_MULT: rd_mux_w = mult_w;
            RA_RDIV: rd_mux_w = {{(REG_W-DIV_W){1'b0}}, rdiv_w};
            default: rd_mux_w = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)       rdata_q <= '0;
        else if (rd_i) rdata_q <= rd_mux_w;
    end

    assign rdata_o   = rdata_q;
    assign mult_o    = mult_w;
    assign div_o     = eff_div(rdiv_w);
    assign pll_on_o  = ctl_w.on;
    assign clk_sel_o = ctl_w.sel;
    assign irq_o     = flag_w && ctl_w.ie;

    assert_rdiv_upper_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_i && addr_w == RA_RDIV) |=> (rdata_q[REG_W-1:DIV_W] == '0));

endmodule

// File: tb/pllcfg_bank_tb.sv
module pllcfg_bank_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] addr;
    logic       wr;
    logic       rd;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic       lock;
    logic [7:0] mult;
    logic [3:0] div;
    logic       pll_on;
    logic       clk_sel;
    logic       irq;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    pllcfg_bank dut_i (
        .clk(clk), .rst(rst), .addr_i(addr), .wr_i(wr), .rd_i(rd),
        .wdata_i(wdata), .rdata_o(rdata), .lock_i(lock), .mult_o(mult),
        .div_o(div), .pll_on_o(pll_on), .clk_sel_o(clk_sel), .irq_o(irq)
    );

    // bench model of register state
    logic [7:0] m_mult;
    logic [3:0] m_rdiv;
    logic m_on, m_sel, m_ie, m_auto, m_flag, m_lock;

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_div(input logic [3:0] r);
        return (r == 4'd0) ? 4'd1 : r;
    endfunction

    function automatic logic [7:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0:    return {m_flag, m_ie, m_on, m_sel, 4'b0};
            2'd1:    return {6'b0, m_lock, m_auto};
            2'd2:    return m_mult;
            default: return {4'b0, m_rdiv};
        endcase
    endfunction

    task automatic model_write(input logic [1:0] a, input logic [7:0] d);
        case (a)
            2'd0: begin m_on = d[5]; m_ie = d[6]; m_sel = d[4] && (m_mult != 0); end
            2'd1: m_auto = d[0];
            2'd2: if (!m_on) begin m_mult = d; if (d == 0) m_sel = 1'b0; end
            default: if (!m_on) m_rdiv = d[3:0];
        endcase
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bus(input logic [1:0] a, input logic w, input logic r, input logic [7:0] d);
        addr = a; wr = w; rd = r; wdata = d;
        tick();
        wr = 1'b0; rd = 1'b0;
    endtask

    task automatic do_write(input logic [1:0] a, input logic [7:0] d);
        bus(a, 1'b1, 1'b0, d);
        model_write(a, d);
    endtask

    task automatic do_read(input string req, input logic [1:0] a);
        logic [7:0] e;
        e = exp_read(a);
        bus(a, 1'b0, 1'b1, 8'h00);
        chk(req, rdata, e);
        if (a == 2'd0) m_flag = 1'b0;
    endtask

    task automatic chk_outs(input string req);
        chk({req, " mult"},  mult,    m_mult);
        chk({req, " div"},   div,     exp_div(m_rdiv));
        chk({req, " on"},    pll_on,  m_on);
        chk({req, " sel"},   clk_sel, m_sel);
        chk({req, " irq"},   irq,     m_flag && m_ie);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'h5eed1234));
        rst = 1'b1; addr = 0; wr = 0; rd = 0; wdata = 0; lock = 0;
        m_mult = 8'h40; m_rdiv = 4'd1; m_on = 0; m_sel = 0; m_ie = 0;
        m_auto = 0; m_flag = 0; m_lock = 0;
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R1 reset state
        chk_outs("R1");
        do_read("R1 ctrl", 2'd0);
        do_read("R1 mode", 2'd1);
        do_read("R11 mult", 2'd2);
        do_read("R11 rdiv", 2'd3);

        // R6 divider zero acts as one, R5 upper bits read 0
        do_write(2'd3, 8'hF0);
        chk("R6 div zero", div, 1);
        do_read("R5 rdiv upper", 2'd3);
        do_write(2'd3, 8'h07);
        chk("R6 div seven", div, 7);

        // R3 zero multiply clears select; R4 select blocked at zero
        do_write(2'd0, 8'h10);
        chk("R4 sel set", clk_sel, 1);
        do_write(2'd2, 8'h00);
        chk("R3 sel cleared", clk_sel, 0);
        chk("R3 still off", pll_on, 0);
        do_write(2'd0, 8'h10);
        chk("R4 sel blocked", clk_sel, 0);
        do_read("R4 ctrl read", 2'd0);

        // R2/R5 writes ignored while on
        do_write(2'd2, 8'h20);
        do_write(2'd0, 8'h30);
        chk("R4 on", pll_on, 1);
        do_write(2'd2, 8'h99);
        chk("R2 mult held", mult, 8'h20);
        do_write(2'd3, 8'h03);
        chk("R5 rdiv held", div, 7);
        do_read("R2 mult read", 2'd2);

        // R10 manual mode: lock changes do not set flag, status follows
        do_write(2'd0, 8'h40);
        lock = 1'b1; m_lock = 1'b1;
        repeat (4) tick();
        chk("R10 irq", irq, 0);
        do_read("R10 ctrl", 2'd0);
        do_read("R7 status", 2'd1);

        // R7 automatic mode, rising then R8 flag/enable gating
        do_write(2'd1, 8'h01);
        lock = 1'b0; m_lock = 1'b0;
        tick(); tick();
        chk("R7 not yet after 2 edges", irq, 0);
        tick();
        chk("R7 set after 3 edges", irq, 1);
        m_flag = 1'b1;
        do_write(2'd0, 8'h00);
        chk("R8 irq masked", irq, 0);
        do_read("R8 flag set ie=0", 2'd0);
        chk("R9 cleared", irq, 0);
        do_write(2'd0, 8'h40);
        chk("R9 irq after clear", irq, 0);

        // R7 rising direction, then R9 same-cycle priority
        lock = 1'b1; m_lock = 1'b1;
        repeat (3) tick();
        chk("R7 rising sets", irq, 1);
        m_flag = 1'b1;
        lock = 1'b0; m_lock = 1'b0;
        tick(); tick();
        bus(2'd0, 1'b0, 1'b1, 8'h00);
        chk("R9 read value", rdata, 8'hC0);
        chk("R9 set wins", irq, 1);
        do_read("R9 second read", 2'd0);
        chk("R9 cleared now", irq, 0);

        // random phase, lock steady
        for (int i = 0; i < 400; i++) begin
            logic [1:0] a;
            logic [7:0] d;
            int k;
            a = 2'($urandom % 4);
            d = ($urandom % 4 == 0) ? 8'h00 : 8'($urandom);
            k = $urandom % 3;
            if (k == 0) do_read("R11 rnd read", a);
            else        do_write(a, d);
            chk_outs("R2 R4 rnd");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule